// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM array alive. After reset it holds off all traffic for a fixed power-up delay. It then runs a burst of warm-up refresh cycles and raises `init_done`, which lets the access controller begin work. From then on it owes one refresh every retention period divided by the row count. Each refresh is a CAS-before-RAS cycle, so the part's own row counter supplies the address and the block never touches the address bus.

The block talks to the access controller through a request/grant pair. While at least one refresh is owed and the block is idle, it raises `ref_req`. In the default waiting mode it starts only when the controller answers with `ref_gnt`. In the pre-emptive mode it starts as soon as a refresh is owed.

A refresh that is not served in its slot stays owed. Once the owed count exceeds the postponement limit, the block takes the bus without a grant. Whenever it owns the bus, it issues every owed refresh back to back in one ownership period. While `ref_own` is high it drives the three strobes. At all other times it holds them high so that the controller can merge them.

Top module: `cbr_refresh_sched`

## Requirements
- R1: During reset `ras_n`, `cas_n` and `we_n` are high, and `ref_own`, `ref_req` and `init_done` are low.
- R2: After reset no refresh starts and `init_done` stays low for at least the power-up delay (POWERUP_NS rounded up to clock cycles).
- R3: After the delay exactly INIT_REFRESHES refresh cycles run in a single ownership period. `init_done` then rises and stays high until reset.
- R4: In every refresh `cas_n` is low for at least one full cycle before `ras_n` falls. `cas_n` stays low for the whole time `ras_n` is low. `we_n` is high when `ras_n` falls.
- R5: `ras_n` stays low for at least the RAS pulse in cycles. Before each fall it has been high for at least the precharge time. Successive falls are at least the full cycle time apart.
- R6: Once `init_done` is high, one refresh becomes owed every RETENTION_NS/ROWS/CLK_NS cycles. `ref_req` is high exactly while a refresh is owed, the block is idle and `init_done` is high.
- R7: With PREEMPT = 0, an owed refresh does not start while `ref_gnt` is low, unless the owed count exceeds MAX_POSTPONE.
- R8: When the owed count exceeds MAX_POSTPONE, the block takes the bus without a grant. It issues all owed refreshes back to back in one ownership period.
- R9: A grant that arrives while several refreshes are owed serves all of them in one ownership period.
- R10: With PREEMPT = 1, every owed refresh starts without a grant, one ownership period per interval.
- R11: `ref_gnt` has no effect while nothing is owed. `ref_own` stays low and `ras_n` stays high.
- R12: `ras_n` and `cas_n` are low only while `ref_own` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Access controller yields the bus |
| ref_req | output | 1 | A refresh is owed and waiting |
| ref_own | output | 1 | Block owns and drives the strobes |
| init_done | output | 1 | Power-up sequence complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The checker assumes that `ref_gnt` matters only when the block asks for the bus. It also assumes that the controller has released the strobes before granting, so the block's own precharge phase is the only history that `ras_n` carries. The stimulus respects both assumptions. It changes `ref_gnt` only at negative clock edges. It raises `ref_gnt` only when the table expects a pending request, or during the window where grants must be ignored. Sample points sit well clear of each interval tick, so a few cycles of pipeline delay cannot move a refresh across a checkpoint.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [2:0] {
        S_PWR  = 3'd0,
        S_IDLE = 3'd1,
        S_PRE  = 3'd2,
        S_CSR  = 3'd3,
        S_RAS  = 3'd4
    } rfs_state_e;

    function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfs_tick_timer.sv
module rfs_tick_timer #(
    parameter int unsigned PERIOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned W = $clog2(PERIOD + 1);
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rfs_owed_ctr.sv
module rfs_owed_ctr #(
    parameter int unsigned CAP = 9,
    parameter int unsigned W   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] owed
);
    logic [W-1:0] owed_d, owed_q;

    always_comb begin
        owed_d = owed_q;
        if (inc && !dec && owed_q != W'(CAP)) owed_d = owed_q + 1'b1;
        if (dec && !inc && owed_q != '0)      owed_d = owed_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) owed_q <= '0;
        else        owed_q <= owed_d;
    end

    assign owed = owed_q;
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
    import rfs_pkg::*;
#(
    parameter int unsigned CLK_NS         = 10,
    parameter int unsigned POWERUP_NS     = 200_000,
    parameter int unsigned INIT_REFRESHES = 8,
    parameter int unsigned RETENTION_NS   = 32_000_000,
    parameter int unsigned ROWS           = 2048,
    parameter int unsigned MAX_POSTPONE   = 8,
    parameter int unsigned PREEMPT        = 0,
    parameter int unsigned TRAS_NS        = 60,
    parameter int unsigned TRP_NS         = 40,
    parameter int unsigned TRC_NS         = 110,
    parameter int unsigned TCSR_NS        = 10,
    parameter int unsigned TCHR_NS        = 10,
    parameter int unsigned TRPC_NS        = 5,
    parameter int unsigned TWRP_NS        = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ref_own,
    output logic init_done,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    localparam int unsigned PWR_CYC  = imax(cdiv(POWERUP_NS, CLK_NS), 2);
    localparam int unsigned INTV_CYC = imax(RETENTION_NS / ROWS / CLK_NS, 2);
    localparam int unsigned CSR_CYC  = imax(imax(cdiv(TCSR_NS, CLK_NS), cdiv(TWRP_NS, CLK_NS)), 1);
    localparam int unsigned RAS_CYC  = imax(imax(cdiv(TRAS_NS, CLK_NS), cdiv(TCHR_NS, CLK_NS)), 1);
    localparam int unsigned RC_CYC   = cdiv(TRC_NS, CLK_NS);
    localparam int unsigned RC_REST  = (RC_CYC > RAS_CYC + CSR_CYC) ? RC_CYC - RAS_CYC - CSR_CYC : 1;
    localparam int unsigned PRE_CYC  = imax(imax(cdiv(TRP_NS, CLK_NS), cdiv(TRPC_NS, CLK_NS)), RC_REST);
    localparam int unsigned CNT_W    = $clog2(imax(imax(PRE_CYC, CSR_CYC), RAS_CYC) + 1);
    localparam int unsigned INIT_W   = $clog2(INIT_REFRESHES + 1);
    localparam int unsigned OWE_CAP  = MAX_POSTPONE + 1;
    localparam int unsigned OWE_W    = $clog2(OWE_CAP + 1);

    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_CYC - 1);
    localparam logic [CNT_W-1:0] CSR_LAST = CNT_W'(CSR_CYC - 1);
    localparam logic [CNT_W-1:0] RAS_LAST = CNT_W'(RAS_CYC - 1);

    typedef struct packed {
        rfs_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [INIT_W-1:0]  left;
        logic               tail;
        logic               done;
        logic               own;
        logic               ras_n;
        logic               cas_n;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: S_PWR, cnt: '0, left: '0, tail: 1'b0,
                                 done: 1'b0, own: 1'b0, ras_n: 1'b1, cas_n: 1'b1};

    seq_t             r_q, r_d;
    logic             pwr_tick, intv_tick, owed_dec, more, urgent;
    logic [OWE_W-1:0] owed;

    rfs_tick_timer #(.PERIOD(PWR_CYC)) u_pwr_timer (
        .clk(clk), .rst_n(rst_n), .en(r_q.st == S_PWR), .tick(pwr_tick)
    );

    rfs_tick_timer #(.PERIOD(INTV_CYC)) u_intv_timer (
        .clk(clk), .rst_n(rst_n), .en(r_q.done), .tick(intv_tick)
    );

    rfs_owed_ctr #(.CAP(OWE_CAP), .W(OWE_W)) u_owed (
        .clk(clk), .rst_n(rst_n), .inc(intv_tick), .dec(owed_dec), .owed(owed)
    );

    always_comb begin
        r_d      = r_q;
        owed_dec = 1'b0;
        urgent   = owed > OWE_W'(MAX_POSTPONE);
        more     = r_q.done ? (owed != '0) : (r_q.left != '0);
        case (r_q.st)
            S_PWR: begin
                if (pwr_tick) begin
                    r_d.st   = S_PRE;
                    r_d.cnt  = '0;
                    r_d.tail = 1'b0;
                    r_d.own  = 1'b1;
                    r_d.left = INIT_W'(INIT_REFRESHES);
                end
            end
            S_IDLE: begin
                if (owed != '0 && (PREEMPT != 0 || ref_gnt || urgent)) begin
                    r_d.st   = S_PRE;
                    r_d.cnt  = '0;
                    r_d.tail = 1'b0;
                    r_d.own  = 1'b1;
                end
            end
            S_PRE: begin
                if (r_q.cnt == PRE_LAST) begin
                    r_d.cnt = '0;
                    if (!r_q.tail || more) begin
                        r_d.st = S_CSR;
                    end else begin
                        r_d.st   = S_IDLE;
                        r_d.own  = 1'b0;
                        r_d.done = 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_CSR: begin
                if (r_q.cnt == CSR_LAST) begin
                    r_d.cnt = '0;
                    r_d.st  = S_RAS;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_RAS: begin
                if (r_q.cnt == RAS_LAST) begin
                    r_d.cnt  = '0;
                    r_d.st   = S_PRE;
                    r_d.tail = 1'b1;
                    if (r_q.done) owed_dec = 1'b1;
                    else          r_d.left = r_q.left - 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d = SEQ_RST;
        endcase
        r_d.ras_n = (r_d.st != S_RAS);
        r_d.cas_n = !(r_d.st == S_CSR || r_d.st == S_RAS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= SEQ_RST;
        else        r_q <= r_d;
    end

    assign ras_n     = r_q.ras_n;
    assign cas_n     = r_q.cas_n;
    assign we_n      = 1'b1;
    assign ref_own   = r_q.own;
    assign init_done = r_q.done;
    assign ref_req   = r_q.done && (r_q.st == S_IDLE) && (owed != '0);
endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk #(
    parameter int unsigned RAS_CYC = 6,
    parameter int unsigned PRE_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ref_gnt,
    input logic ref_req,
    input logic ref_own,
    input logic init_done,
    input logic ras_n,
    input logic cas_n,
    input logic we_n
);
    logic [15:0] lo_cnt_q, hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt_q <= '0;
            hi_cnt_q <= '0;
        end else begin
            lo_cnt_q <= ras_n ? '0 : ((lo_cnt_q == 16'hFFFF) ? lo_cnt_q : lo_cnt_q + 1'b1);
            hi_cnt_q <= !ras_n ? '0 : ((hi_cnt_q == 16'hFFFF) ? hi_cnt_q : hi_cnt_q + 1'b1);
        end
    end

    assert_strobes_owned_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_own |-> (ras_n && cas_n));

    assert_cas_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && !$past(cas_n) && we_n));

    assert_cas_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (lo_cnt_q >= 16'(RAS_CYC)));

    assert_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt_q >= 16'(PRE_CYC)));

    assert_init_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_req_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> (!ref_own && init_done));

    assert_no_early_own_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !ref_own) |-> !ref_req);

    logic unused_gnt;
    assign unused_gnt = ref_gnt;
endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk #(.RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req), .ref_own(ref_own),
    .init_done(init_done), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
);

// File: tb/cbr_refresh_sched_test.sv
module cbr_refresh_sched_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0;
    always #5 clk = ~clk;

    logic req, own, idone, ras_n, cas_n, we_n;
    logic p_req, p_own, p_idone, p_ras_n, p_cas_n, p_we_n;

    // Bench timing: 200-cycle power-up, 3 warm-up refreshes, 100-cycle interval, limit 2
    cbr_refresh_sched #(.CLK_NS(10), .POWERUP_NS(2000), .INIT_REFRESHES(3), .RETENTION_NS(8000),
                        .ROWS(8), .MAX_POSTPONE(2), .PREEMPT(0)) uut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req), .ref_own(own),
        .init_done(idone), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

    cbr_refresh_sched #(.CLK_NS(10), .POWERUP_NS(2000), .INIT_REFRESHES(3), .RETENTION_NS(8000),
                        .ROWS(8), .MAX_POSTPONE(2), .PREEMPT(1)) uut_pre (
        .clk(clk), .rst_n(rst_n), .ref_gnt(1'b0), .ref_req(p_req), .ref_own(p_own),
        .init_done(p_idone), .ras_n(p_ras_n), .cas_n(p_cas_n), .we_n(p_we_n));

    int n_run = 0, n_fail = 0, cyc = 0;
    int rf_cnt = 0, own_rises = 0, pr_cnt = 0, pr_owns = 0;
    int hi_run = 0, lo_run = 0, since_fall = 0;
    bit seen_fall = 0;
    logic m_ras = 1'b1, m_cas = 1'b1, m_own = 1'b0, m_pras = 1'b1, m_pown = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Strobe monitor: counts refreshes and checks each one's timing
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (m_ras && !ras_n) begin
                rf_cnt++;
                check(m_cas == 1'b0, "R4 cas low before ras", int'(m_cas), 0);
                check(we_n == 1'b1, "R4 we high at ras fall", int'(we_n), 1);
                check(hi_run >= 4, "R5 precharge cycles", hi_run, 4);
                check(own == 1'b1, "R12 owned during strobe", int'(own), 1);
                if (seen_fall) check(since_fall >= 11, "R5 fall-to-fall cycles", since_fall, 11);
                since_fall = 0;
                seen_fall  = 1;
            end
            if (!m_ras && ras_n) begin
                check(lo_run >= 6, "R5 ras low cycles", lo_run, 6);
                check(m_cas == 1'b0, "R4 cas held through ras", int'(m_cas), 0);
            end
            if (ras_n) begin hi_run++; lo_run = 0; end
            else       begin lo_run++; hi_run = 0; end
            since_fall++;
            if (own && !m_own) own_rises++;
            if (m_pras && !p_ras_n) pr_cnt++;
            if (p_own && !m_pown) pr_owns++;
        end
        m_ras = ras_n; m_cas = cas_n; m_own = own; m_pras = p_ras_n; m_pown = p_own;
    end

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Table: sample offset after init_done, expected refresh count, ref_req, ownership rises, grant to drive next
    localparam int N_STEP = 8;
    localparam int T_AT  [N_STEP] = '{150, 250, 360, 450, 550, 590, 750, 790};
    localparam int T_CNT [N_STEP] = '{  3,   3,   6,   7,   7,   8,   8,  10};
    localparam int T_REQ [N_STEP] = '{  1,   1,   0,   0,   1,   0,   1,   0};
    localparam int T_OWN [N_STEP] = '{  1,   1,   2,   3,   3,   4,   4,   5};
    localparam int T_GNT [N_STEP] = '{  0,   0,   1,   0,   1,   0,   1,   1};

    initial begin
        int rel, t0, c0, o0;
        bit ras_ok;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ras_n == 1'b1 && cas_n == 1'b1 && we_n == 1'b1, "R1 strobes high", int'({ras_n, cas_n, we_n}), 7);
        check(own == 1'b0, "R1 ref_own low", int'(own), 0);
        check(req == 1'b0, "R1 ref_req low", int'(req), 0);
        check(idone == 1'b0, "R1 init_done low", int'(idone), 0);
        rst_n = 1'b1;
        rel = cyc;
        // R2: still waiting
        wait_until(rel + 150);
        check(idone == 1'b0, "R2 init_done during wait", int'(idone), 0);
        check(rf_cnt == 0, "R2 no refresh during wait", rf_cnt, 0);
        check(own == 1'b0, "R2 no ownership during wait", int'(own), 0);
        while (!idone && cyc < rel + 2000) @(negedge clk);
        t0 = cyc;
        check(idone == 1'b1, "R3 init_done raised", int'(idone), 1);
        check(t0 - rel >= 200, "R2 power-up delay cycles", t0 - rel, 200);
        check(rf_cnt == 3, "R3 warm-up refresh count", rf_cnt, 3);
        check(own_rises == 1, "R3 warm-up in one ownership", own_rises, 1);
        // R6 R7 R8 R9: scheduling table
        for (int i = 0; i < N_STEP; i++) begin
            wait_until(t0 + T_AT[i]);
            check(rf_cnt == T_CNT[i], $sformatf("R7/R8/R9 step %0d refresh count", i), rf_cnt, T_CNT[i]);
            check(int'(req) == T_REQ[i], $sformatf("R6 step %0d ref_req", i), int'(req), T_REQ[i]);
            check(own_rises == T_OWN[i], $sformatf("R8/R9 step %0d ownership periods", i), own_rises, T_OWN[i]);
            check(idone == 1'b1, $sformatf("R3 step %0d init_done held", i), int'(idone), 1);
            gnt = T_GNT[i][0];
        end
        // R10: pre-emptive instance served every interval with no grant
        check(pr_cnt == 10, "R10 pre-emptive refresh count", pr_cnt, 10);
        check(pr_owns == 8, "R10 pre-emptive ownership periods", pr_owns, 8);
        // R11: grant toggling with nothing owed
        wait_until(t0 + 830);
        c0 = rf_cnt; o0 = own_rises; ras_ok = 1;
        for (int k = 0; k < 60; k++) begin
            gnt = ~gnt;
            @(negedge clk);
            if (!ras_n || own) ras_ok = 0;
        end
        gnt = 1'b0;
        check(own_rises == o0, "R11 no ownership from idle grant", own_rises, o0);
        check(rf_cnt == c0, "R11 no refresh from idle grant", rf_cnt, c0);
        check(ras_ok, "R11 strobes idle during grant toggles", int'(ras_ok), 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog R3 actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    logic unused_tb;
    assign unused_tb = ^{p_req, p_idone, p_cas_n, p_we_n};
endmodule